// File: doc/BRIEF.md
# Bit-Slip Word Alignment Controller

This controller sits beside a bit-slip word aligner. It steers the aligner's slip input until the received words fall on the right boundary. It raises the slip request, holds it for a fixed time, and lowers it again. Each rising edge asks the aligner to move its boundary by one bit. After each slip the controller lets the aligner settle, then checks whether alignment has been reached.

A mode input selects how a match is judged. In one mode the controller uses the aligner's pattern-detect flag. In the other it compares the received word with an expected word. Once a match is seen, slipping stops and the boundary is left alone. The controller then watches for loss of lock, and it starts searching again if the match disappears for several cycles in a row. If a full round of slips finds no match, the controller signals an error and begins a fresh round.

Top module: `bitslip_align_ctrl`

## Requirements
- R1: While the synchronous reset is high, slip_req, aligned and search_err are all low. In the first cycle after reset the controller makes a check and does not slip.
- R2: During a search, each slip holds slip_req high for exactly SLIP_HI (2) cycles. Consecutive rising edges of slip_req are exactly SLIP_HI+SLIP_LO (4) cycles apart.
- R3: If the check in the first cycle after reset is a match, the controller locks without issuing any slip. aligned is then high after the 2nd clock edge following reset.
- R4: With use_word = 0, a match means pat_det is high, and exp_word has no effect. With use_word = 1, a match means rx_word equals exp_word, and pat_det has no effect.
- R5: A check falls on the last cycle of each settle interval. When the check after the t-th slip is a match, aligned rises after clock edge 2+4t counted from the release of reset. No further rising edge of slip_req follows.
- R6: When 16 slips in a row end with no match, search_err is high for exactly one cycle, after clock edge 2+4·16 (66). A new round of 16 slips then starts, and the next error pulse comes 64 cycles later (edge 130).
- R7: While locked, aligned stays high through up to 3 consecutive cycles without a match. It falls after the 4th consecutive cycle without a match.
- R8: After loss of lock, the next cycle is a check. If that check matches, aligned returns the cycle after it, with no slip issued.
- R9: aligned is never high in the same cycle as slip_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| use_word | input | 1 | Match source: 0 uses pat_det, 1 compares rx_word with exp_word |
| pat_det | input | 1 | Pattern-detect flag from the aligner |
| rx_word | input | DW | Word from the aligner output |
| exp_word | input | DW | Expected word at the correct boundary |
| slip_req | output | 1 | Slip request to the aligner; each rising edge slips one bit |
| aligned | output | 1 | High while locked |
| search_err | output | 1 | One-cycle pulse when a round of slips found no match |

## Verification
The assertions rely on a few things the aligner and the user must guarantee. use_word must stay constant throughout a search and while locked. The aligner must move its boundary only in response to a rising edge of slip_req, so that a match seen at a check reflects the slips issued up to that point. The bench holds use_word and exp_word fixed for each run. It models the aligner as a rotation of a repeating byte that advances by one bit on each rising edge of slip_req, which keeps the detect flag and the received word consistent with each other. It applies corruption only while the controller is locked.

// File: rtl/bitslip_align_ctrl.sv
module bitslip_align_ctrl #(
  parameter int DW         = 8,
  parameter int SLIP_HI    = 2,
  parameter int SLIP_LO    = 2,
  parameter int MAX_SLIPS  = 16,
  parameter int LOSS_LIMIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          use_word,
  input  logic          pat_det,
  input  logic [DW-1:0] rx_word,
  input  logic [DW-1:0] exp_word,
  output logic          slip_req,
  output logic          aligned,
  output logic          search_err
);

  localparam int TW  = $clog2(SLIP_HI + SLIP_LO + 1);
  localparam int SCW = $clog2(MAX_SLIPS + 1);
  localparam int MCW = $clog2(LOSS_LIMIT + 1);
  localparam logic [TW-1:0]  HI_LAST   = TW'(SLIP_HI - 1);
  localparam logic [TW-1:0]  WAIT_LAST = TW'((SLIP_LO > 1) ? SLIP_LO - 2 : 0);
  localparam logic [SCW-1:0] SLIP_TOP  = SCW'(MAX_SLIPS);
  localparam logic [MCW-1:0] MISS_TOP  = MCW'(LOSS_LIMIT - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SLIP, ST_WAIT, ST_CHECK, ST_LOCKED} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [SCW-1:0] slips;
  logic [MCW-1:0] misses;

  wire hit = use_word ? (rx_word == exp_word) : pat_det;

  assign slip_req = (st == ST_SLIP);
  assign aligned  = (st == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      tmr        <= '0;
      slips      <= '0;
      misses     <= '0;
      search_err <= 1'b0;
    end else begin
      search_err <= 1'b0;
      case (st)
        ST_IDLE: begin
          slips <= '0;
          st    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (hit) begin
            misses <= '0;
            st     <= ST_LOCKED;
          end else begin
            tmr <= '0;
            st  <= ST_SLIP;
            if (slips == SLIP_TOP) begin
              search_err <= 1'b1;
              slips      <= SCW'(1);
            end else begin
              slips <= slips + 1'b1;
            end
          end
        end
        ST_SLIP: begin
          if (tmr == HI_LAST) begin
            tmr <= '0;
            st  <= (SLIP_LO > 1) ? ST_WAIT : ST_CHECK;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAIT: begin
          if (tmr == WAIT_LAST) begin
            tmr <= '0;
            st  <= ST_CHECK;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (hit) begin
            misses <= '0;
          end else if (misses == MISS_TOP) begin
            misses <= '0;
            slips  <= '0;
            st     <= ST_CHECK;
          end else begin
            misses <= misses + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slip_req) |=> slip_req);

  // R2
  slip_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(slip_req) |=> !slip_req);

  // R5
  lock_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(hit));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    search_err |=> !search_err);

  // R9
  lock_no_slip_chk: assert property (@(posedge clk) disable iff (rst)
    aligned |-> !slip_req);

  // R7
  miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
    misses <= MISS_TOP);

endmodule

// File: tb/bitslip_align_ctrl_tb.sv
module bitslip_align_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       use_word = 1'b0;
  logic       force_det = 1'b0;
  logic       det_on = 1'b1;
  logic       corrupt = 1'b0;
  int         target = 0;
  logic [2:0] off;
  logic       slip_q;
  logic       slip_req, aligned, search_err;
  logic       pat_det;
  logic [7:0] rx_word, exp_word;
  int         cyc;
  int         rises, last_rise, hi_len, shape_bad;
  logic       prev_n;
  int         vecs = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rotr(input int k);
    logic [15:0] d;
    d = {8'hF0, 8'hF0} >> (k % 8);
    return d[7:0];
  endfunction

  assign pat_det  = force_det | (det_on && (int'(off) == target) && !corrupt);
  assign rx_word  = rotr(int'(off)) ^ {7'd0, corrupt};
  assign exp_word = (use_word && target < 8) ? rotr(target) : 8'h55;

  bitslip_align_ctrl dut_i (
    .clk(clk), .rst(rst), .use_word(use_word), .pat_det(pat_det),
    .rx_word(rx_word), .exp_word(exp_word), .slip_req(slip_req),
    .aligned(aligned), .search_err(search_err)
  );

  always @(posedge clk) begin
    if (rst) begin
      off <= 3'd0; slip_q <= 1'b0; cyc <= 0;
    end else begin
      slip_q <= slip_req;
      if (slip_req && !slip_q) off <= off + 3'd1;
      cyc <= cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      rises = 0; last_rise = 0; hi_len = 0; shape_bad = 0; prev_n = 1'b0;
    end else begin
      if (slip_req && !prev_n) begin
        if (rises > 0 && cyc - last_rise != 4) shape_bad++;
        rises++; last_rise = cyc; hi_len = 1;
      end else if (slip_req) begin
        hi_len++;
      end else if (prev_n && hi_len != 2) begin
        shape_bad++;
      end
      if (slip_req && aligned) shape_bad++;
      prev_n = slip_req;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; corrupt = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!slip_req && !aligned && !search_err, "R1", {slip_req, aligned, search_err}, 0);
    rst = 1'b0;
  endtask

  task automatic run_lock(input bit mode, input int t);
    int n;
    use_word = mode; target = t; det_on = 1'b1; force_det = mode;
    do_reset();
    n = 0;
    while (!aligned && n < 200) begin @(negedge clk); n++; end
    if (t == 0) chk(cyc == 2 && rises == 0, "R3", cyc, 2);
    chk(cyc == 2 + 4 * t, mode ? "R4/R5 word mode" : "R4/R5 detect mode", cyc, 2 + 4 * t);
    repeat (6) @(negedge clk);
    chk(rises == t && aligned, "R5 slips stop", rises, t);
    chk(shape_bad == 0, "R2 R9", shape_bad, 0);
  endtask

  initial begin
    #(5ns * 20000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int r;
    for (int m = 0; m < 2; m++)
      for (int t = 0; t < 8; t++) run_lock(m[0], t);

    for (int m = 0; m < 2; m++) begin
      run_lock(m[0], 3);
      r = rises;
      corrupt = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(aligned == 1'b1, "R7 short loss", aligned, 1);
      end
      corrupt = 1'b0;
      @(negedge clk);
      chk(aligned == 1'b1, "R7 kept", aligned, 1);
      corrupt = 1'b1;
      repeat (3) @(negedge clk);
      chk(aligned == 1'b1, "R7 three misses", aligned, 1);
      @(negedge clk);
      chk(aligned == 1'b0, "R7 fourth miss", aligned, 0);
      corrupt = 1'b0;
      @(negedge clk);
      chk(aligned == 1'b1 && rises == r, "R8 relock", rises, r);
    end

    use_word = 1'b0; force_det = 1'b0; det_on = 1'b0; target = 8;
    do_reset();
    r = 0;
    while (!search_err && r < 300) begin @(negedge clk); r++; end
    chk(cyc == 66, "R6 first error", cyc, 66);
    @(negedge clk);
    chk(search_err == 1'b0 && aligned == 1'b0, "R6 pulse width", search_err, 0);
    r = 0;
    while (!search_err && r < 300) begin @(negedge clk); r++; end
    chk(cyc == 130, "R6 second error", cyc, 130);
    chk(shape_bad == 0, "R2 long search", shape_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule